// File: doc/BRIEF.md
# Paged Memory Bus Slave

This block is a 32-bit synchronous bus slave that exposes a 4 KB address window as eight pages of 512 bytes each. The pages are modelled as byte-wide RAMs inside the block, each with a registered output that can be forced to zero. A bus master presents an address, write data, a read/write direction flag and a select strobe. It holds select until it sees the acknowledge, and it drops select in the cycle after.

Every bus input is captured in a register before any decode, because these inputs arrive late in the clock period. The captured address is then compared with the window base. Address bits [11:9] pick one page and bits [8:0] pick the byte within it. A two-stage cycle chain produces the acknowledge and also blocks a new access while a transfer is still in flight. A read returns its byte copied onto all four lanes of the return bus. The error, retry and timeout-suppress outputs are always low.

Top module: `pbr_bridge`

## Requirements
- R1: After a synchronous active-low reset, the acknowledge, the error, retry and timeout-suppress outputs, and all 32 bits of the read data bus are 0.
- R2: Select is sampled at the clock edge that follows the cycle in which the master drives it. The acknowledge is high in the second cycle after that edge, which is the third cycle counted from the one in which select is first driven.
- R3: Each accepted transfer produces exactly one single-cycle acknowledge. If select stays high, a new access is accepted only after the acknowledge cycle has passed, so the acknowledges are three cycles apart.
- R4: An access is accepted only when address bits [31:12] equal the window base (default 0xFEFF1000). Any other address is never acknowledged, and a write to it leaves every page unchanged.
- R5: Address bits [11:9] select the page as an unsigned number 0 to 7, and bits [8:0] select the byte within it. A byte written to any page and offset reads back unchanged, and it does not disturb the other pages.
- R6: A write (direction flag 0) stores write data bits [7:0]. Bits [31:8] have no effect on the stored byte.
- R7: A read (direction flag 1) returns the addressed byte on all four byte lanes, [31:24], [23:16], [15:8] and [7:0], during the acknowledge cycle.
- R8: The read data bus is all zero in every cycle that is not a read acknowledge. This includes the acknowledge cycle of a write and the cycle after every acknowledge.
- R9: The error, retry and timeout-suppress outputs stay 0 at all times.
- R10: The write enable of a page lasts exactly one cycle per write, and at most one page is enabled at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 32 | Byte address |
| bus_wdata_i | input | 32 | Write data; only [7:0] is stored |
| bus_rnw_i | input | 1 | 1 = read, 0 = write |
| bus_sel_i | input | 1 | Transfer request strobe |
| bus_rdata_o | output | 32 | Read data, byte replicated on four lanes |
| bus_ack_o | output | 1 | Transfer acknowledge |
| bus_err_o | output | 1 | Error response, constant 0 |
| bus_retry_o | output | 1 | Retry request, constant 0 |
| bus_tosup_o | output | 1 | Timeout suppress, constant 0 |

## Verification
The acknowledge and the read byte appear together in the third cycle after select is first driven. They come through the input register, the page output register and the cycle chain / return data register. The bench drives its inputs on the falling edge and samples once per falling edge. It records the sample index at which the acknowledge first appears and expects exactly 3. It then checks that the following sample shows the acknowledge low and the data bus at zero. For a select held over six samples, the acknowledge is expected at samples 3 and 6 only. An address outside the window is watched for eight samples with no acknowledge, and the in-window byte that shares its low address bits is then read back unchanged.

// File: rtl/pbr_pkg.sv
// Package: shared widths and the captured bus request type.
// Assumes a 32-bit address and data bus; the page geometry stays a module parameter.
package pbr_pkg;
    localparam int BUS_AW = 32;
    localparam int BUS_DW = 32;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] wdata;
        logic              rnw;
        logic              sel;
    } bus_req_t;
endpackage

// File: rtl/pbr_in_reg.sv
// pbr_in_reg: captures every bus input on each clock before any decode.
// Assumes inputs are valid only near the end of the cycle; reset gives rnw=1, rest 0.
module pbr_in_reg
    import pbr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_req_t req_i,
    output bus_req_t req_q
);
    // Capture the raw bus inputs every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q.addr  <= '0;
            req_q.wdata <= '0;
            req_q.rnw   <= 1'b1;
            req_q.sel   <= 1'b0;
        end else begin
            req_q <= req_i;
        end
    end
endmodule

// File: rtl/pbr_cycle_ctrl.sv
// pbr_cycle_ctrl: window decode, page select and the two-stage cycle chain.
// Assumes the request is already registered; emits per-page write and output-clear controls.
module pbr_cycle_ctrl
    import pbr_pkg::*;
#(
    parameter logic [BUS_AW-1:0] BASE_ADDR  = 32'hFEFF_1000,
    parameter int                PAGE_BYTES = 512,
    parameter int                PAGES      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  bus_req_t                      req_q,
    output logic                          rd_phase_o,
    output logic                          ack_o,
    output logic [PAGES-1:0]              page_we_o,
    output logic [PAGES-1:0]              page_clr_o,
    output logic [$clog2(PAGE_BYTES)-1:0] page_off_o
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = $clog2(PAGES);
    localparam int WIN_W = OFF_W + PG_W;

    logic             busy1_q, busy2_q;
    logic             hit;
    logic             accept;
    logic [PAGES-1:0] pg_onehot;

    // Window match on the upper address bits.
    assign hit    = (req_q.addr[BUS_AW-1:WIN_W] == BASE_ADDR[BUS_AW-1:WIN_W]);
    assign accept = req_q.sel && hit && !busy1_q && !busy2_q;

    // One-hot page select from the page field of the address.
    always_comb begin
        pg_onehot = '0;
        pg_onehot[req_q.addr[WIN_W-1:OFF_W]] = 1'b1;
    end

    // Cycle chain: stage 1 follows accept, stage 2 follows stage 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy1_q <= 1'b0;
            busy2_q <= 1'b0;
        end else begin
            busy1_q <= accept;
            busy2_q <= busy1_q;
        end
    end

    // Page controls: write strobe and output-clear, gated by reset.
    always_comb begin
        page_we_o  = '0;
        page_clr_o = '1;
        if (accept && rst_n) begin
            if (req_q.rnw) page_clr_o = ~pg_onehot;
            else           page_we_o  = pg_onehot;
        end
    end

    assign page_off_o = req_q.addr[OFF_W-1:0];
    assign rd_phase_o = busy1_q;
    assign ack_o      = busy2_q;

    // R10: a write strobe never spans two cycles
    p_we_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|page_we_o) |=> !(|page_we_o));
    // R10: at most one page written at once
    p_we_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(page_we_o));
    // R3: the two chain stages are never set together
    p_chain_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy1_q && busy2_q));
endmodule

// File: rtl/pbr_page_ram.sv
// pbr_page_ram: behavioural byte-wide page with a registered output.
// Assumes clr=1 forces the output register to zero (a write under clr still stores).
module pbr_page_ram
    import pbr_pkg::*;
#(
    parameter int PAGE_BYTES = 512
) (
    input  logic                          clk,
    input  logic                          we_i,
    input  logic                          clr_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] off_i,
    input  logic [BYTE_W-1:0]             din_i,
    output logic [BYTE_W-1:0]             dout_o
);
    logic [BYTE_W-1:0] mem [PAGE_BYTES];

    // Store the byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we_i) mem[off_i] <= din_i;
    end

    // Output register: cleared, write-through, or read.
    always_ff @(posedge clk) begin
        if (clr_i)     dout_o <= '0;
        else if (we_i) dout_o <= din_i;
        else           dout_o <= mem[off_i];
    end
endmodule

// File: rtl/pbr_bridge.sv
// pbr_bridge: bus slave mapping a window onto PAGES byte-wide pages.
// Assumes the master holds select until acknowledged; returns read bytes on all lanes.
module pbr_bridge
    import pbr_pkg::*;
#(
    parameter logic [BUS_AW-1:0] BASE_ADDR  = 32'hFEFF_1000,
    parameter int                PAGE_BYTES = 512,
    parameter int                PAGES      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic [BUS_DW-1:0] bus_wdata_i,
    input  logic              bus_rnw_i,
    input  logic              bus_sel_i,
    output logic [BUS_DW-1:0] bus_rdata_o,
    output logic              bus_ack_o,
    output logic              bus_err_o,
    output logic              bus_retry_o,
    output logic              bus_tosup_o
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int LANES = BUS_DW / BYTE_W;

    bus_req_t          req_raw, req_q;
    logic              rd_phase;
    logic [PAGES-1:0]  page_we, page_clr;
    logic [OFF_W-1:0]  page_off;
    logic [BYTE_W-1:0] page_dout [PAGES];
    logic [BYTE_W-1:0] rd_byte;
    logic [BUS_DW-1:0] rdata_q;
    logic              unused_wbits;

    assign req_raw = '{addr: bus_addr_i, wdata: bus_wdata_i,
                       rnw: bus_rnw_i, sel: bus_sel_i};

    pbr_in_reg u_in (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_raw),
        .req_q (req_q)
    );

    pbr_cycle_ctrl #(
        .BASE_ADDR  (BASE_ADDR),
        .PAGE_BYTES (PAGE_BYTES),
        .PAGES      (PAGES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_q      (req_q),
        .rd_phase_o (rd_phase),
        .ack_o      (bus_ack_o),
        .page_we_o  (page_we),
        .page_clr_o (page_clr),
        .page_off_o (page_off)
    );

    for (genvar p = 0; p < PAGES; p++) begin : g_page
        pbr_page_ram #(.PAGE_BYTES(PAGE_BYTES)) u_ram (
            .clk    (clk),
            .we_i   (page_we[p]),
            .clr_i  (page_clr[p]),
            .off_i  (page_off),
            .din_i  (req_q.wdata[BYTE_W-1:0]),
            .dout_o (page_dout[p])
        );
    end

    // Merge the page outputs; only the selected page can be nonzero.
    always_comb begin
        rd_byte = '0;
        if (rd_phase) begin
            for (int p = 0; p < PAGES; p++) rd_byte = rd_byte | page_dout[p];
        end
    end

    // Register the read byte, copied to every lane.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= {LANES{rd_byte}};
    end

    assign bus_rdata_o  = rdata_q;
    assign bus_err_o    = 1'b0;
    assign bus_retry_o  = 1'b0;
    assign bus_tosup_o  = 1'b0;
    assign unused_wbits = ^req_q.wdata[BUS_DW-1:BYTE_W];

    // R2: an acknowledge starts two cycles after the latched select
    p_ack_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack_o) |-> $past(req_q.sel, 2));
    // R3: acknowledge lasts a single cycle
    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_o |=> !bus_ack_o);
    // R8: data bus idle outside the acknowledge cycle
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack_o |-> (bus_rdata_o == '0));
    // R7: all lanes carry the same byte
    p_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o == {LANES{bus_rdata_o[BYTE_W-1:0]}});
endmodule

// File: tb/pbr_bridge_tb_top.sv
// Directed bench for pbr_bridge: one task per scenario, each checking its own results.
module pbr_bridge_tb_top;
    localparam logic [31:0] BASE = 32'hFEFF_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic        rnw = 1'b1, sel = 1'b0;
    logic [31:0] rdata;
    logic        ack, err, retry, tosup;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pbr_bridge dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rnw_i   (rnw),
        .bus_sel_i   (sel),
        .bus_rdata_o (rdata),
        .bus_ack_o   (ack),
        .bus_err_o   (err),
        .bus_retry_o (retry),
        .bus_tosup_o (tosup)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] win(input int pg, input int off);
        return BASE | (32'(pg) << 9) | 32'(off);
    endfunction

    // One transfer: latency of first ack (0 = none within 8), data at ack, idle after.
    task automatic xfer(input logic [31:0] a, input logic r, input logic [31:0] d,
                        output logic [31:0] rd, output int lat, output bit idle_ok);
        @(negedge clk);
        addr = a; rnw = r; wdata = d; sel = 1'b1;
        lat = 0; rd = '0;
        for (int i = 1; i <= 8 && lat == 0; i++) begin
            @(negedge clk);
            if (ack) begin lat = i; rd = rdata; sel = 1'b0; end
        end
        sel = 1'b0;
        @(negedge clk);
        idle_ok = (ack == 1'b0) && (rdata == '0);
    endtask

    task automatic t_reset;
        check(ack == 1'b0, "R1 ack after reset", 32'(ack), 0);
        check(rdata == '0, "R1 rdata after reset", rdata, 0);
        check({err, retry, tosup} == 3'b000, "R1 side outputs after reset",
              32'({err, retry, tosup}), 0);
    endtask

    task automatic t_all_pages;
        logic [31:0] rd; int lat; bit idle;
        for (int p = 0; p < 8; p++) begin
            xfer(win(p, 0), 1'b0, 32'(8'h10 + p * 8'h11), rd, lat, idle);
            check(lat == 3, "R2 write ack latency", 32'(lat), 3);
            check(rd == '0, "R8 rdata zero at write ack", rd, 0);
            check(idle, "R8 idle after write ack", 32'(idle), 1);
            xfer(win(p, 511), 1'b0, 32'(8'hF0 - p * 8'h07), rd, lat, idle);
        end
        for (int p = 0; p < 8; p++) begin
            logic [7:0] e0, e1;
            e0 = 8'(8'h10 + p * 8'h11);
            e1 = 8'(8'hF0 - p * 8'h07);
            xfer(win(p, 0), 1'b1, '0, rd, lat, idle);
            check(lat == 3, "R2 read ack latency", 32'(lat), 3);
            check(rd == {4{e0}}, "R5 R7 page readback offset 0", rd, {4{e0}});
            check(idle, "R8 idle after read ack", 32'(idle), 1);
            xfer(win(p, 511), 1'b1, '0, rd, lat, idle);
            check(rd == {4{e1}}, "R5 R7 page readback offset 511", rd, {4{e1}});
        end
    endtask

    task automatic t_upper_bits;
        logic [31:0] rd; int lat; bit idle;
        xfer(win(3, 100), 1'b0, 32'hABCD_EF5A, rd, lat, idle);
        xfer(win(3, 100), 1'b1, '0, rd, lat, idle);
        check(rd == 32'h5A5A_5A5A, "R6 only low byte stored", rd, 32'h5A5A_5A5A);
    endtask

    task automatic t_outside;
        logic [31:0] rd; int lat; bit idle;
        xfer(32'hFEFE_0000, 1'b0, 32'h0000_00EE, rd, lat, idle);
        check(lat == 0, "R4 no ack outside window (write)", 32'(lat), 0);
        xfer(32'hFEFF_2000, 1'b1, '0, rd, lat, idle);
        check(lat == 0, "R4 no ack outside window (read)", 32'(lat), 0);
        check(rdata == '0, "R8 rdata zero with no transfer", rdata, 0);
        xfer(win(0, 0), 1'b1, '0, rd, lat, idle);
        check(rd == {4{8'h10}}, "R4 outside write left page 0 intact", rd, {4{8'h10}});
    endtask

    task automatic t_hold;
        bit exp_ack;
        @(negedge clk);
        addr = win(2, 0); rnw = 1'b1; sel = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            exp_ack = (i == 3) || (i == 6);
            check(ack == exp_ack, "R3 held select ack spacing", 32'(ack), 32'(exp_ack));
            if (exp_ack)
                check(rdata == {4{8'h32}}, "R7 held select data", rdata, {4{8'h32}});
        end
        sel = 1'b0;
        @(negedge clk);
        check(ack == 1'b0, "R3 no ack after held select drops", 32'(ack), 0);
    endtask

    task automatic t_side_outputs;
        check({err, retry, tosup} == 3'b000, "R9 side outputs stay low",
              32'({err, retry, tosup}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_pages();
        t_upper_bits();
        t_outside();
        t_hold();
        t_side_outputs();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule